// File: doc/BRIEF.md
# Two-Wide Register Rename Stage with Checkpoint-Free Recovery

This block translates the architectural register numbers of up to two instructions per cycle into physical register tags. A speculative map gives each source its current physical tag. Each instruction that writes a register takes a fresh physical tag from a circular free queue, and the tag that destination held before is reported alongside it. When both instructions of a group are renamed together, the second one sees the first one's new mapping in the same cycle. Lane 0 is the older instruction.

A second map holds the committed state. It changes only through the in-order commit port, which gives the architectural register and its physical tag for up to two retiring instructions. The tag that the committed map held before is returned to the tail of the free queue. A recovery pulse discards all speculative state. The speculative map becomes a copy of the committed map, and the free queue is refilled with every physical register that the committed map does not reference.

Top module: `reg_rename`

## Requirements
- R1: After reset, architectural register n maps to physical tag n on every source and previous-destination output.
- R2: Architectural register 0 always yields tag 0. A destination of 0 takes no physical register, and its destination and previous tags read 0.
- R3: Writing lanes receive tags in free-queue order, lane 0 before lane 1. After reset the queue holds tags 32 to 63 in ascending order.
- R4: Within one group, lane 1 sources and its previous tag that name lane 0's destination get lane 0's new tag.
- R5: Renamed mappings persist, so later groups read the most recent tag given to each architectural register.
- R6: `ren_ready` is low when fewer free tags remain than writing lanes in the group. In that case no tag is consumed and the map is unchanged. A group that writes nothing is always accepted outside recovery.
- R7: A commit of a nonzero register replaces its committed tag. The replaced tag is appended to the free queue, lane 0 before lane 1, and tags are reused in that order once earlier entries are consumed.
- R8: While `recover` is high, `ren_ready` is low. From the next cycle the speculative map equals the committed map, including commits made in the recovery cycle.
- R9: After recovery, the free queue holds exactly the tags the committed map does not reference, in ascending order.
- R10: Two commits to the same register in one cycle free the older committed tag and then lane 0's tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 2 | Instruction present, per lane |
| ren_src_a | input | 2x5 | First source architectural register, per lane |
| ren_src_b | input | 2x5 | Second source architectural register, per lane |
| ren_dst | input | 2x5 | Destination architectural register, per lane |
| ren_ready | output | 1 | Group accepted this cycle |
| tag_src_a | output | 2x6 | Physical tag of first source |
| tag_src_b | output | 2x6 | Physical tag of second source |
| tag_dst | output | 2x6 | Newly assigned destination tag |
| tag_prev | output | 2x6 | Destination's mapping before this instruction |
| cmt_valid | input | 2 | Commit present, per lane, in program order |
| cmt_arch | input | 2x5 | Committed destination register |
| cmt_phys | input | 2x6 | Committed destination tag |
| recover | input | 1 | Restore speculative state from committed state |

## Verification
A corrupted free-queue entry or pointer does not show up right away. It appears only when that slot is popped, up to 32 allocations later, as a wrong or duplicated destination tag. For this reason the bench runs long enough to cycle the queue several times. A stale speculative map entry shows up on the first source read of that register. A wrong committed map shows up only after the next recovery, in the source tags or in the order the queue is rebuilt. For that reason, recoveries are mixed among the commits.

// File: rtl/rn_pkg.sv
package rn_pkg;
    localparam int unsigned RN_LANES = 2;
endpackage

// File: rtl/rn_free_list.sv
module rn_free_list #(
    parameter int unsigned NUM_ARCH = 32,
    parameter int unsigned NUM_PHYS = 64,
    localparam int unsigned DEPTH = NUM_PHYS - NUM_ARCH,
    localparam int unsigned PW = $clog2(NUM_PHYS),
    localparam int unsigned IW = $clog2(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [1:0]                       pop_cnt,
    input  logic [rn_pkg::RN_LANES-1:0]      push_vld,
    input  logic [rn_pkg::RN_LANES-1:0][PW-1:0] push_tag,
    input  logic                             rebuild,
    input  logic [NUM_ARCH-1:0][PW-1:0]      rebuild_map,
    output logic [rn_pkg::RN_LANES-1:0][PW-1:0] head_tag,
    output logic [CW-1:0]                    avail
);
    typedef struct packed {
        logic [DEPTH-1:0][PW-1:0] ent;
        logic [IW-1:0]            head;
        logic [IW-1:0]            tail;
        logic [CW-1:0]            cnt;
    } fl_state_t;

    function automatic fl_state_t reset_state();
        fl_state_t s;
        for (int i = 0; i < int'(DEPTH); i++) begin
            s.ent[i] = PW'(NUM_ARCH + i);
        end
        s.head = '0;
        s.tail = '0;
        s.cnt  = CW'(DEPTH);
        return s;
    endfunction

    fl_state_t state_d, state_q;

    always_comb begin
        logic [NUM_PHYS-1:0] used;
        logic [IW-1:0]       wp;
        logic [1:0]          npush;
        int unsigned         idx;
        state_d = state_q;
        used    = '0;
        idx     = 0;
        wp      = state_q.tail;
        npush   = '0;
        if (rebuild) begin
            for (int a = 0; a < int'(NUM_ARCH); a++) begin
                used[rebuild_map[a]] = 1'b1;
            end
            for (int p = 0; p < int'(NUM_PHYS); p++) begin
                if (!used[p] && idx < DEPTH) begin
                    state_d.ent[idx[IW-1:0]] = PW'(p);
                    idx = idx + 1;
                end
            end
            state_d.head = '0;
            state_d.tail = IW'(idx);
            state_d.cnt  = CW'(idx);
        end else begin
            for (int l = 0; l < int'(rn_pkg::RN_LANES); l++) begin
                if (push_vld[l]) begin
                    state_d.ent[wp] = push_tag[l];
                    wp    = wp + 1'b1;
                    npush = npush + 1'b1;
                end
            end
            state_d.tail = wp;
            state_d.head = state_q.head + IW'(pop_cnt);
            state_d.cnt  = state_q.cnt - CW'(pop_cnt) + CW'(npush);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= reset_state();
        else        state_q <= state_d;
    end

    assign head_tag[0] = state_q.ent[state_q.head];
    assign head_tag[1] = state_q.ent[state_q.head + 1'b1];
    assign avail       = state_q.cnt;
endmodule

// File: rtl/rn_commit_map.sv
module rn_commit_map #(
    parameter int unsigned NUM_ARCH = 32,
    parameter int unsigned NUM_PHYS = 64,
    localparam int unsigned AW = $clog2(NUM_ARCH),
    localparam int unsigned PW = $clog2(NUM_PHYS)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [rn_pkg::RN_LANES-1:0]         cmt_vld,
    input  logic [rn_pkg::RN_LANES-1:0][AW-1:0] cmt_arch,
    input  logic [rn_pkg::RN_LANES-1:0][PW-1:0] cmt_phys,
    output logic [rn_pkg::RN_LANES-1:0]         free_vld,
    output logic [rn_pkg::RN_LANES-1:0][PW-1:0] free_tag,
    output logic [NUM_ARCH-1:0][PW-1:0]         map_next
);
    typedef logic [NUM_ARCH-1:0][PW-1:0] cmap_t;

    function automatic cmap_t identity_map();
        cmap_t m;
        for (int a = 0; a < int'(NUM_ARCH); a++) m[a] = PW'(a);
        return m;
    endfunction

    cmap_t map_d, map_q;

    always_comb begin
        map_d    = map_q;
        free_vld = '0;
        free_tag = '0;
        for (int l = 0; l < int'(rn_pkg::RN_LANES); l++) begin
            if (cmt_vld[l] && cmt_arch[l] != '0) begin
                free_vld[l]         = 1'b1;
                free_tag[l]         = map_d[cmt_arch[l]];
                map_d[cmt_arch[l]]  = cmt_phys[l];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) map_q <= identity_map();
        else        map_q <= map_d;
    end

    assign map_next = map_d;
endmodule

// File: rtl/reg_rename.sv
module reg_rename #(
    parameter int unsigned NUM_ARCH = 32,
    parameter int unsigned NUM_PHYS = 64,
    localparam int unsigned AW = $clog2(NUM_ARCH),
    localparam int unsigned PW = $clog2(NUM_PHYS),
    localparam int unsigned CW = $clog2(NUM_PHYS - NUM_ARCH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       ren_valid,
    input  logic [1:0][AW-1:0] ren_src_a,
    input  logic [1:0][AW-1:0] ren_src_b,
    input  logic [1:0][AW-1:0] ren_dst,
    output logic             ren_ready,
    output logic [1:0][PW-1:0] tag_src_a,
    output logic [1:0][PW-1:0] tag_src_b,
    output logic [1:0][PW-1:0] tag_dst,
    output logic [1:0][PW-1:0] tag_prev,
    input  logic [1:0]       cmt_valid,
    input  logic [1:0][AW-1:0] cmt_arch,
    input  logic [1:0][PW-1:0] cmt_phys,
    input  logic             recover
);
    typedef logic [NUM_ARCH-1:0][PW-1:0] smap_t;

    function automatic smap_t identity_map();
        smap_t m;
        for (int a = 0; a < int'(NUM_ARCH); a++) m[a] = PW'(a);
        return m;
    endfunction

    smap_t spec_d, spec_q;

    logic [1:0]         pop_cnt;
    logic [1:0]         free_vld;
    logic [1:0][PW-1:0] free_tag;
    logic [1:0][PW-1:0] head_tag;
    logic [CW-1:0]      fl_avail;
    smap_t              commit_next;

    rn_commit_map #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_cmap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmt_vld  (cmt_valid),
        .cmt_arch (cmt_arch),
        .cmt_phys (cmt_phys),
        .free_vld (free_vld),
        .free_tag (free_tag),
        .map_next (commit_next)
    );

    rn_free_list #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_free (
        .clk         (clk),
        .rst_n       (rst_n),
        .pop_cnt     (pop_cnt),
        .push_vld    (free_vld),
        .push_tag    (free_tag),
        .rebuild     (recover),
        .rebuild_map (commit_next),
        .head_tag    (head_tag),
        .avail       (fl_avail)
    );

    always_comb begin
        smap_t      work;
        logic [1:0] k;
        logic [1:0] need;
        work      = spec_q;
        k         = '0;
        need      = '0;
        tag_src_a = '0;
        tag_src_b = '0;
        tag_dst   = '0;
        tag_prev  = '0;
        for (int l = 0; l < 2; l++) begin
            if (ren_valid[l] && ren_dst[l] != '0) need = need + 1'b1;
        end
        ren_ready = !recover && (fl_avail >= CW'(need));
        // Walk the lanes in program order so lane 1 reads lane 0's update.
        for (int l = 0; l < 2; l++) begin
            tag_src_a[l] = work[ren_src_a[l]];
            tag_src_b[l] = work[ren_src_b[l]];
            if (ren_valid[l] && ren_dst[l] != '0) begin
                tag_prev[l]       = work[ren_dst[l]];
                tag_dst[l]        = head_tag[k[0]];
                work[ren_dst[l]]  = head_tag[k[0]];
                k                 = k + 1'b1;
            end
        end
        pop_cnt = ren_ready ? k : 2'd0;
        if (recover)        spec_d = commit_next;
        else if (ren_ready) spec_d = work;
        else                spec_d = spec_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) spec_q <= identity_map();
        else        spec_q <= spec_d;
    end
endmodule

// File: rtl/rn_checker.sv
module rn_checker #(
    parameter int unsigned NUM_ARCH = 32,
    parameter int unsigned NUM_PHYS = 64,
    localparam int unsigned AW = $clog2(NUM_ARCH),
    localparam int unsigned PW = $clog2(NUM_PHYS),
    localparam int unsigned CW = $clog2(NUM_PHYS - NUM_ARCH + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         ren_valid,
    input logic [1:0][AW-1:0] ren_src_a,
    input logic [1:0][AW-1:0] ren_dst,
    input logic               ren_ready,
    input logic [1:0][PW-1:0] tag_src_a,
    input logic [1:0][PW-1:0] tag_dst,
    input logic [1:0][PW-1:0] tag_prev,
    input logic               recover,
    input logic [CW-1:0]      fl_avail
);
    logic w0, w1;
    assign w0 = ren_valid[0] && ren_dst[0] != '0;
    assign w1 = ren_valid[1] && ren_dst[1] != '0;

    a_r2_zero_src0: assert property (@(posedge clk) disable iff (!rst_n)
        ren_valid[0] && ren_src_a[0] == '0 |-> tag_src_a[0] == '0);
    a_r2_zero_src1: assert property (@(posedge clk) disable iff (!rst_n)
        ren_valid[1] && ren_src_a[1] == '0 && !(w0 && ren_dst[0] == '0) |-> tag_src_a[1] == '0);
    a_r3_distinct_dst: assert property (@(posedge clk) disable iff (!rst_n)
        ren_ready && w0 && w1 |-> tag_dst[0] != tag_dst[1]);
    a_r4_bypass_src: assert property (@(posedge clk) disable iff (!rst_n)
        ren_ready && w0 && ren_valid[1] && ren_src_a[1] == ren_dst[0] |-> tag_src_a[1] == tag_dst[0]);
    a_r4_bypass_prev: assert property (@(posedge clk) disable iff (!rst_n)
        ren_ready && w0 && w1 && ren_dst[1] == ren_dst[0] |-> tag_prev[1] == tag_dst[0]);
    a_r6_enough_free: assert property (@(posedge clk) disable iff (!rst_n)
        ren_ready |-> fl_avail >= CW'(w0) + CW'(w1));
    a_r8_recover_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        recover |-> !ren_ready);
    a_r9_rebuilt_full: assert property (@(posedge clk) disable iff (!rst_n)
        recover |=> fl_avail == CW'(NUM_PHYS - NUM_ARCH));
endmodule

bind reg_rename rn_checker #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ren_valid (ren_valid),
    .ren_src_a (ren_src_a),
    .ren_dst   (ren_dst),
    .ren_ready (ren_ready),
    .tag_src_a (tag_src_a),
    .tag_dst   (tag_dst),
    .tag_prev  (tag_prev),
    .recover   (recover),
    .fl_avail  (fl_avail)
);

// File: tb/reg_rename_test.sv
`timescale 1ns/1ps
module reg_rename_test;
    localparam int NA = 32;
    localparam int NP = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] ren_valid = '0;
    logic [1:0][4:0] ren_src_a = '0, ren_src_b = '0, ren_dst = '0;
    logic ren_ready;
    logic [1:0][5:0] tag_src_a, tag_src_b, tag_dst, tag_prev;
    logic [1:0] cmt_valid = '0;
    logic [1:0][4:0] cmt_arch = '0;
    logic [1:0][5:0] cmt_phys = '0;
    logic recover = 1'b0;

    always #2 clk = ~clk;

    reg_rename uut (
        .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_src_a(ren_src_a),
        .ren_src_b(ren_src_b), .ren_dst(ren_dst), .ren_ready(ren_ready),
        .tag_src_a(tag_src_a), .tag_src_b(tag_src_b), .tag_dst(tag_dst),
        .tag_prev(tag_prev), .cmt_valid(cmt_valid), .cmt_arch(cmt_arch),
        .cmt_phys(cmt_phys), .recover(recover)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int smap [NA];
    int cmap [NA];
    int fq [$];
    int pend_a [$];
    int pend_p [$];
    int unsigned seed = 32'h1234_5678;

    function automatic int unsigned rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed >> 8;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(input string req, input logic [1:0] v,
                        input int sa0, input int sb0, input int d0,
                        input int sa1, input int sb1, input int d1,
                        input logic [1:0] cv, input logic rec);
        int sa[2], sb[2], d[2], nw, ca[2], cp[2];
        logic [1:0] cvv;
        bit rdy;
        sa[0] = sa0; sb[0] = sb0; d[0] = d0;
        sa[1] = sa1; sb[1] = sb1; d[1] = d1;
        cvv = '0;
        for (int l = 0; l < 2; l++) begin
            ca[l] = 0; cp[l] = 0;
            if (cv[l] && pend_a.size() > 0) begin
                cvv[l] = 1'b1;
                ca[l] = pend_a.pop_front();
                cp[l] = pend_p.pop_front();
            end
        end
        ren_valid = v;
        for (int l = 0; l < 2; l++) begin
            ren_src_a[l] = 5'(sa[l]); ren_src_b[l] = 5'(sb[l]); ren_dst[l] = 5'(d[l]);
            cmt_arch[l] = 5'(ca[l]); cmt_phys[l] = 6'(cp[l]);
        end
        cmt_valid = cvv;
        recover = rec;
        #1;
        nw = 0;
        for (int l = 0; l < 2; l++) if (v[l] && d[l] != 0) nw++;
        rdy = !rec && fq.size() >= nw;
        check(rec ? "R8" : "R6", "ren_ready", int'(ren_ready), int'(rdy));
        if (rdy) begin
            for (int l = 0; l < 2; l++) begin
                if (v[l]) begin
                    check(req, $sformatf("lane%0d src_a", l), int'(tag_src_a[l]), smap[sa[l]]);
                    check(req, $sformatf("lane%0d src_b", l), int'(tag_src_b[l]), smap[sb[l]]);
                    if (d[l] != 0) begin
                        check(req, $sformatf("lane%0d prev", l), int'(tag_prev[l]), smap[d[l]]);
                        check(req, $sformatf("lane%0d dst", l), int'(tag_dst[l]), fq[0]);
                        smap[d[l]] = fq.pop_front();
                        pend_a.push_back(d[l]);
                        pend_p.push_back(smap[d[l]]);
                    end else begin
                        check("R2", $sformatf("lane%0d dst0", l), int'(tag_dst[l]), 0);
                        check("R2", $sformatf("lane%0d prev0", l), int'(tag_prev[l]), 0);
                    end
                end
            end
        end
        for (int l = 0; l < 2; l++) begin
            if (cvv[l] && ca[l] != 0) begin
                fq.push_back(cmap[ca[l]]);
                cmap[ca[l]] = cp[l];
            end
        end
        if (rec) begin
            bit used [NP];
            for (int p = 0; p < NP; p++) used[p] = 0;
            for (int a = 0; a < NA; a++) begin
                smap[a] = cmap[a];
                used[cmap[a]] = 1;
            end
            fq.delete();
            for (int p = 0; p < NP; p++) if (!used[p]) fq.push_back(p);
            pend_a.delete();
            pend_p.delete();
        end
        @(posedge clk);
        @(negedge clk);
        ren_valid = '0; cmt_valid = '0; recover = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < NA; a++) begin smap[a] = a; cmap[a] = a; end
        for (int p = NA; p < NP; p++) fq.push_back(p);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", "reset ready", int'(ren_ready), 1);
        @(negedge clk);

        // R1/R2: sweep every architectural register through both lanes, no writes.
        for (int i = 0; i < NA / 2; i++)
            step("R1", 2'b11, 2*i, 2*i+1, 0, NA-1-2*i, NA-2-2*i, 0, 2'b00, 1'b0);
        // R3: first allocations come out in ascending order.
        step("R3", 2'b11, 1, 2, 5, 3, 4, 6, 2'b00, 1'b0);
        step("R3", 2'b01, 5, 6, 7, 0, 0, 0, 2'b00, 1'b0);
        step("R3", 2'b10, 0, 0, 0, 7, 5, 8, 2'b00, 1'b0);
        // R4: lane 1 reads and overwrites lane 0's destination.
        step("R4", 2'b11, 9, 5, 10, 10, 10, 10, 2'b00, 1'b0);
        step("R4", 2'b11, 10, 0, 11, 11, 10, 12, 2'b00, 1'b0);
        // R5: later groups see the latest mappings.
        step("R5", 2'b11, 10, 11, 0, 12, 5, 0, 2'b00, 1'b0);
        // R6: exhaust the free queue without commits.
        for (int i = 0; i < 14; i++)
            step("R6", 2'b11, i+1, i+2, (i % 31) + 1, i, i+3, ((i+7) % 31) + 1, 2'b00, 1'b0);
        step("R6", 2'b11, 1, 2, 3, 4, 5, 6, 2'b00, 1'b0);
        step("R6", 2'b11, 1, 2, 0, 4, 5, 0, 2'b00, 1'b0);
        // R7: commits return tags; a single writer then proceeds.
        step("R7", 2'b00, 0, 0, 0, 0, 0, 0, 2'b01, 1'b0);
        step("R7", 2'b11, 3, 4, 9, 1, 2, 13, 2'b00, 1'b0);
        step("R7", 2'b01, 3, 4, 9, 1, 2, 13, 2'b11, 1'b0);
        // R10: two renames of one register, then commit both together.
        step("R10", 2'b00, 0, 0, 0, 0, 0, 0, 2'b00, 1'b1);
        step("R10", 2'b11, 20, 21, 20, 20, 21, 20, 2'b00, 1'b0);
        step("R10", 2'b00, 0, 0, 0, 0, 0, 0, 2'b11, 1'b0);
        // R8/R9: recover with same-cycle commits, then use the rebuilt state.
        step("R8", 2'b11, 1, 2, 3, 3, 4, 5, 2'b00, 1'b0);
        step("R8", 2'b11, 3, 5, 6, 20, 6, 7, 2'b01, 1'b1);
        step("R9", 2'b11, 3, 5, 20, 20, 6, 7, 2'b00, 1'b0);
        for (int i = 0; i < 16; i++)
            step("R9", 2'b11, i, i+1, i+2, i+3, i+4, i+5, 2'b00, 1'b0);
        // Long mixed run: all requirements under pseudo-random traffic.
        for (int i = 0; i < 4000; i++) begin
            int unsigned r;
            r = rnd();
            step("R5", 2'(r), int'(rnd() % NA), int'(rnd() % NA), int'(rnd() % NA),
                 int'(rnd() % NA), int'(rnd() % NA), int'(rnd() % NA),
                 2'(rnd()), (rnd() % 40) == 0);
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule